// File: doc/BRIEF.md
# Streaming 2D Electromagnetic Field Update Engine

This block performs one time step of the two-dimensional finite-difference time-domain field update on data that arrives as a stream. The three field grids (two electric components, here called Ex and Ey, and the magnetic component Hz) enter together, one grid point per accepted cycle, in raster order: column index running fastest, then row. Neighbours are found at fixed stream distances. The point before or after in the same row is one position away. The point in the row above or below is one row length away. A circular line store holds the recent points so that these neighbours are available, including the values ahead of the current point that the Hz update needs.

Software first sets the row length, the row count, four signed fixed-point coefficients, a boundary margin width and the source coordinates. A start pulse latches all of them. The engine then takes exactly rows×cols points. After the last input it drains its remaining points by itself and emits the updated fields in input order, then raises a done flag. A neighbour that falls outside the grid reads as zero. Points in the boundary margin get zero fields. At the source point, the live source value replaces the Hz result.

Top module: `fdtd_stream_engine`

## Requirements
- R1: After reset, out_valid and done are 0.
- R2: For a non-margin point, new Ex = trunc((ca·Ex)>>>F + (cb·(Hz − Hz_west))>>>F). Hz_west is the Hz of the previous point in the same row, and it reads 0 in column 0.
- R3: For a non-margin point, new Ey = trunc((ca·Ey)>>>F + (cb·(Hz_north − Hz))>>>F). Hz_north is the Hz one row length earlier in the stream, and it reads 0 in row 0.
- R4: For a non-margin, non-source point, new Hz = trunc((da·Hz)>>>F + (db·(Ex_east − Ex + Ey'_here − Ey'_south))>>>F). Ex_east is the next point's input Ex (0 in the last column). Ey' is the final new Ey of the point and of the point one row below (0 in the last row).
- R5: A point is in the margin when col < M, col ≥ cols−M, row < M or row ≥ rows−M, where M is cfg_margin. Its Ex, Ey and Hz outputs are 0, and its zero Ey' is the value that R4 uses. M = 0 gives no margin.
- R6: At col = cfg_src_x and row = cfg_src_y, out_hz equals src_value as it stands in the emitting cycle. This takes priority over R5 and leaves Ex and Ey unaffected.
- R7: Outputs keep raster order. Point j is emitted one cycle after the point j+cols+1 is accepted. Once the last point has been accepted, one point is emitted every cycle until the grid is complete.
- R8: in_valid has no effect before start, and extra points beyond rows×cols have no effect. Exactly rows×cols outputs are produced per run.
- R9: done rises in the same cycle as the last out_valid and stays high, with no further output, until the next start.
- R10: Products are full precision and shifted right arithmetically by F = 12. The sum wraps to 16-bit two's complement.
- R11: The configuration is latched at start. Changing the cfg_ inputs during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latches configuration and begins a run (idle only) |
| cfg_ca | input | 16 | Signed Ex/Ey self coefficient, Q3.12 |
| cfg_cb | input | 16 | Signed Ex/Ey curl coefficient, Q3.12 |
| cfg_da | input | 16 | Signed Hz self coefficient, Q3.12 |
| cfg_db | input | 16 | Signed Hz curl coefficient, Q3.12 |
| cfg_cols | input | 5 | Row length, 2..16 |
| cfg_rows | input | 5 | Row count, 1..16 |
| cfg_margin | input | 5 | Boundary margin width |
| cfg_src_x | input | 5 | Source column |
| cfg_src_y | input | 5 | Source row |
| src_value | input | 16 | Signed Hz value forced at the source |
| in_valid | input | 1 | Input point present |
| in_ex | input | 16 | Signed Ex of the input point |
| in_ey | input | 16 | Signed Ey of the input point |
| in_hz | input | 16 | Signed Hz of the input point |
| out_valid | output | 1 | Output point present |
| out_ex | output | 16 | Updated Ex |
| out_ey | output | 16 | Updated Ey |
| out_hz | output | 16 | Updated Hz |
| done | output | 1 | Run complete |

## Verification
The assertions check the following on every cycle:
- margin outputs always carry zero electric fields;
- done only rises together with a final output and is followed by silence;
- the input position counter is frozen while idle;
- position counters and line-store addresses stay in range;
- the emitted count never exceeds the grid size.

The arithmetic can only be shown by the bench's scenarios, which compare every output against a behavioural grid model. These cover:
- the stencil arithmetic, including the forward-looking use of the next row's new Ey;
- zero reads at every grid edge;
- wrap-around with extreme operands;
- the emission cycle under gapped and continuous input;
- the effect of a configuration change mid-run.

// File: rtl/fdtd_pkg.sv
package fdtd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } eng_state_e;

    // True when a grid position lies inside the boundary margin.
    function automatic logic in_margin(input int col, input int row,
                                       input int cols, input int rows,
                                       input int margin);
        return (col < margin) || (col >= cols - margin) ||
               (row < margin) || (row >= rows - margin);
    endfunction

endpackage

// File: rtl/fdtd_mac2.sv
// Two-term fixed-point multiply-accumulate: y = trunc((c0*a)>>>F + (c1*b)>>>F)
module fdtd_mac2 #(
    parameter int W    = 16,
    parameter int DW   = 18,
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic signed [CW-1:0] c0,
    input  logic signed [W-1:0]  a,
    input  logic signed [CW-1:0] c1,
    input  logic signed [DW-1:0] b,
    output logic signed [W-1:0]  y
);
    localparam int PW = CW + DW + 1;

    logic signed [PW-1:0] prod0;
    logic signed [PW-1:0] prod1;

    always_comb begin
        prod0 = PW'(c0) * PW'(a);
        prod1 = PW'(c1) * PW'(b);
        y     = W'((prod0 >>> FRAC) + (prod1 >>> FRAC));
    end
endmodule

// File: rtl/fdtd_coord_cnt.sv
// Raster position counter: column wraps at limit, row advances on wrap.
module fdtd_coord_cnt #(
    parameter int XW = 5,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [XW-1:0] limit,
    output logic [XW-1:0] col,
    output logic [YW-1:0] row
);
    typedef struct packed {
        logic [XW-1:0] col;
        logic [YW-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (step) begin
            if (pos_q.col == limit - 1'b1) begin
                pos_d.col = '0;
                pos_d.row = pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign col = pos_q.col;
    assign row = pos_q.row;

    // Column never reaches the row length once a length is set (R7 ordering)
    assert_col_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0 && !$past(clear) && $past(limit) == limit) |-> (pos_q.col < limit));
endmodule

// File: rtl/fdtd_line_buf.sv
// Circular store with one write port and NRD combinational read ports.
module fdtd_line_buf #(
    parameter int EW    = 32,
    parameter int DEPTH = 18,
    parameter int NRD   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [EW-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0][EW-1:0]  rd_data
);
    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_data[k] = mem_q[rd_addr[k]];
        // Read pointers derived in the engine stay inside the store (R7)
        assert_rd_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (int'(rd_addr[k]) < DEPTH));
    end

    assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/fdtd_stream_engine.sv
module fdtd_stream_engine
    import fdtd_pkg::*;
#(
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int MAXN = 16,
    parameter int MAXM = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic signed [CW-1:0]                cfg_ca,
    input  logic signed [CW-1:0]                cfg_cb,
    input  logic signed [CW-1:0]                cfg_da,
    input  logic signed [CW-1:0]                cfg_db,
    input  logic [$clog2(MAXN+1)-1:0]           cfg_cols,
    input  logic [$clog2(MAXM+1)-1:0]           cfg_rows,
    input  logic [$clog2(MAXN+1)-1:0]           cfg_margin,
    input  logic [$clog2(MAXN+1)-1:0]           cfg_src_x,
    input  logic [$clog2(MAXM+1)-1:0]           cfg_src_y,
    input  logic signed [W-1:0]                 src_value,
    input  logic                                in_valid,
    input  logic signed [W-1:0]                 in_ex,
    input  logic signed [W-1:0]                 in_ey,
    input  logic signed [W-1:0]                 in_hz,
    output logic                                out_valid,
    output logic signed [W-1:0]                 out_ex,
    output logic signed [W-1:0]                 out_ey,
    output logic signed [W-1:0]                 out_hz,
    output logic                                done
);
    localparam int XW    = $clog2(MAXN + 1);
    localparam int YW    = $clog2(MAXM + 1);
    localparam int DW    = W + 2;
    localparam int DEPTH = MAXN + 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNTW  = $clog2(MAXN * MAXM + MAXN + 2);

    typedef struct packed {
        logic signed [W-1:0] ex_raw;
        logic signed [W-1:0] hz;
    } raw_cell_t;

    typedef struct packed {
        logic signed [W-1:0] ex_new;
        logic signed [W-1:0] ey_new;
    } new_cell_t;

    typedef struct packed {
        eng_state_e           st;
        logic signed [CW-1:0] ca;
        logic signed [CW-1:0] cb;
        logic signed [CW-1:0] da;
        logic signed [CW-1:0] db;
        logic [XW-1:0]        cols;
        logic [YW-1:0]        rows;
        logic [XW-1:0]        margin;
        logic [XW-1:0]        sx;
        logic [YW-1:0]        sy;
        logic [CNTW-1:0]      total;
        logic [CNTW-1:0]      in_cnt;
        logic [CNTW-1:0]      out_cnt;
        logic [AW-1:0]        wp;
        logic signed [W-1:0]  hz_prev;
        logic signed [W-1:0]  ey_prev;
        logic                 out_valid;
        logic signed [W-1:0]  out_ex;
        logic signed [W-1:0]  out_ey;
        logic signed [W-1:0]  out_hz;
        logic                 out_bnd;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    // ---------------- advance control ----------------
    logic start_ok, adv, emit;
    logic signed [W-1:0] d_ex, d_ey, d_hz;

    always_comb begin
        start_ok = start && (r_q.st == ST_IDLE);
        adv      = ((r_q.st == ST_RUN) && in_valid) || (r_q.st == ST_FLUSH);
        emit     = adv && (r_q.in_cnt > CNTW'(r_q.cols));
        d_ex     = (r_q.st == ST_RUN) ? in_ex : '0;
        d_ey     = (r_q.st == ST_RUN) ? in_ey : '0;
        d_hz     = (r_q.st == ST_RUN) ? in_hz : '0;
    end

    // ---------------- position counters ----------------
    logic [XW-1:0] icol, ocol;
    logic [YW-1:0] irow, orow;

    fdtd_coord_cnt #(.XW(XW), .YW(YW)) i_in_pos (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .step(adv),
        .limit(r_q.cols), .col(icol), .row(irow)
    );

    fdtd_coord_cnt #(.XW(XW), .YW(YW)) i_out_pos (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .step(emit),
        .limit(r_q.cols), .col(ocol), .row(orow)
    );

    // ---------------- line store addressing ----------------
    logic [AW:0]   ra_sum;
    logic [AW-1:0] ra_ahead, rb_out;

    always_comb begin
        ra_sum = {1'b0, r_q.wp} + (AW+1)'(DEPTH) - (AW+1)'(r_q.cols);
        if (ra_sum >= (AW+1)'(DEPTH)) ra_sum = ra_sum - (AW+1)'(DEPTH);
        ra_ahead = AW'(ra_sum);
        rb_out   = (ra_ahead == '0) ? AW'(DEPTH - 1) : ra_ahead - 1'b1;
    end

    raw_cell_t                 raw_wr;
    new_cell_t                 new_wr;
    logic [1:0][AW-1:0]        raw_rd_addr;
    logic [1:0][$bits(raw_cell_t)-1:0] raw_rd_data;
    logic [0:0][AW-1:0]        new_rd_addr;
    logic [0:0][$bits(new_cell_t)-1:0] new_rd_data;
    raw_cell_t                 raw_ahead, raw_out;
    new_cell_t                 new_out;

    assign raw_rd_addr[0] = ra_ahead;
    assign raw_rd_addr[1] = rb_out;
    assign new_rd_addr[0] = rb_out;
    assign raw_ahead      = raw_rd_data[0];
    assign raw_out        = raw_rd_data[1];
    assign new_out        = new_rd_data[0];

    fdtd_line_buf #(.EW($bits(raw_cell_t)), .DEPTH(DEPTH), .NRD(2), .AW(AW)) i_raw_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(adv), .wr_addr(r_q.wp), .wr_data(raw_wr),
        .rd_addr(raw_rd_addr), .rd_data(raw_rd_data)
    );

    fdtd_line_buf #(.EW($bits(new_cell_t)), .DEPTH(DEPTH), .NRD(1), .AW(AW)) i_new_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(adv), .wr_addr(r_q.wp), .wr_data(new_wr),
        .rd_addr(new_rd_addr), .rd_data(new_rd_data)
    );

    // ---------------- electric field update at input point ----------------
    logic signed [W-1:0]  hz_west, hz_north, ex_calc, ey_calc;
    logic signed [DW-1:0] ex_diff, ey_diff;
    logic                 in_bnd;

    always_comb begin
        hz_west  = (icol == '0) ? '0 : r_q.hz_prev;
        hz_north = (irow == '0) ? '0 : raw_ahead.hz;
        ex_diff  = DW'(d_hz) - DW'(hz_west);
        ey_diff  = DW'(hz_north) - DW'(d_hz);
        in_bnd   = in_margin(int'(icol), int'(irow), int'(r_q.cols),
                             int'(r_q.rows), int'(r_q.margin));
    end

    fdtd_mac2 #(.W(W), .DW(DW), .CW(CW), .FRAC(FRAC)) i_ex_mac (
        .c0(r_q.ca), .a(d_ex), .c1(r_q.cb), .b(ex_diff), .y(ex_calc)
    );

    fdtd_mac2 #(.W(W), .DW(DW), .CW(CW), .FRAC(FRAC)) i_ey_mac (
        .c0(r_q.ca), .a(d_ey), .c1(r_q.cb), .b(ey_diff), .y(ey_calc)
    );

    always_comb begin
        raw_wr.ex_raw = d_ex;
        raw_wr.hz     = d_hz;
        new_wr.ex_new = in_bnd ? '0 : ex_calc;
        new_wr.ey_new = in_bnd ? '0 : ey_calc;
    end

    // ---------------- magnetic field update at output point ----------------
    logic signed [W-1:0]  ex_east, ey_south, hz_calc, hz_sel;
    logic signed [DW-1:0] hz_diff;
    logic                 out_bnd, out_src;

    always_comb begin
        ex_east  = (ocol == r_q.cols - 1'b1) ? '0 : raw_ahead.ex_raw;
        ey_south = (orow == r_q.rows - 1'b1) ? '0 : r_q.ey_prev;
        hz_diff  = DW'(ex_east) - DW'(raw_out.ex_raw) + DW'(new_out.ey_new) - DW'(ey_south);
        out_bnd  = in_margin(int'(ocol), int'(orow), int'(r_q.cols),
                             int'(r_q.rows), int'(r_q.margin));
        out_src  = (ocol == r_q.sx) && (orow == r_q.sy);
    end

    fdtd_mac2 #(.W(W), .DW(DW), .CW(CW), .FRAC(FRAC)) i_hz_mac (
        .c0(r_q.da), .a(raw_out.hz), .c1(r_q.db), .b(hz_diff), .y(hz_calc)
    );

    always_comb begin
        if (out_src)      hz_sel = src_value;
        else if (out_bnd) hz_sel = '0;
        else              hz_sel = hz_calc;
    end

    // ---------------- next state ----------------
    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        if (start_ok) begin
            r_d.st      = ST_RUN;
            r_d.ca      = cfg_ca;
            r_d.cb      = cfg_cb;
            r_d.da      = cfg_da;
            r_d.db      = cfg_db;
            r_d.cols    = cfg_cols;
            r_d.rows    = cfg_rows;
            r_d.margin  = cfg_margin;
            r_d.sx      = cfg_src_x;
            r_d.sy      = cfg_src_y;
            r_d.total   = CNTW'(cfg_cols) * CNTW'(cfg_rows);
            r_d.in_cnt  = '0;
            r_d.out_cnt = '0;
            r_d.wp      = '0;
            r_d.done    = 1'b0;
        end else begin
            if (adv) begin
                r_d.in_cnt  = r_q.in_cnt + 1'b1;
                r_d.wp      = (r_q.wp == AW'(DEPTH - 1)) ? '0 : r_q.wp + 1'b1;
                r_d.hz_prev = d_hz;
                r_d.ey_prev = new_wr.ey_new;
                if (r_q.st == ST_RUN && r_q.in_cnt + 1'b1 == r_q.total) r_d.st = ST_FLUSH;
            end
            if (emit) begin
                r_d.out_valid = 1'b1;
                r_d.out_ex    = new_out.ex_new;
                r_d.out_ey    = new_out.ey_new;
                r_d.out_hz    = hz_sel;
                r_d.out_bnd   = out_bnd;
                r_d.out_cnt   = r_q.out_cnt + 1'b1;
                if (r_q.out_cnt + 1'b1 == r_q.total) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_ex    = r_q.out_ex;
    assign out_ey    = r_q.out_ey;
    assign out_hz    = r_q.out_hz;
    assign done      = r_q.done;

    // ---------------- assertions ----------------
    assert_bnd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.out_valid && r_q.out_bnd) |-> (r_q.out_ex == '0 && r_q.out_ey == '0));

    assert_done_with_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> r_q.out_valid);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && $past(r_q.done)) |-> !r_q.out_valid);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.out_cnt <= r_q.total);

    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !start) |=> $stable(r_q.in_cnt));
endmodule

// File: tb/test_fdtd_stream_engine.sv
`timescale 1ns/1ps
module test_fdtd_stream_engine;
    localparam int MAXN = 16;
    localparam int MAXM = 16;
    localparam int F    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] cfg_ca = '0, cfg_cb = '0, cfg_da = '0, cfg_db = '0;
    logic [4:0] cfg_cols = '0, cfg_rows = '0, cfg_margin = '0, cfg_src_x = '0, cfg_src_y = '0;
    logic signed [15:0] src_value = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_ex = '0, in_ey = '0, in_hz = '0;
    logic out_valid, done;
    logic signed [15:0] out_ex, out_ey, out_hz;

    always #4 clk = ~clk;

    fdtd_stream_engine i_fdtd_stream_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_ca(cfg_ca), .cfg_cb(cfg_cb), .cfg_da(cfg_da), .cfg_db(cfg_db),
        .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_margin(cfg_margin),
        .cfg_src_x(cfg_src_x), .cfg_src_y(cfg_src_y), .src_value(src_value),
        .in_valid(in_valid), .in_ex(in_ex), .in_ey(in_ey), .in_hz(in_hz),
        .out_valid(out_valid), .out_ex(out_ex), .out_ey(out_ey), .out_hz(out_hz),
        .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // grid inputs and expected outputs
    logic signed [15:0] gex [MAXM][MAXN];
    logic signed [15:0] gey [MAXM][MAXN];
    logic signed [15:0] ghz [MAXM][MAXN];
    logic signed [15:0] eex [MAXM][MAXN];
    logic signed [15:0] eey [MAXM][MAXN];
    logic signed [15:0] ehz [MAXM][MAXN];
    int                 ecls [MAXM][MAXN];   // 0 interior, 1 margin, 2 source
    string              ex_tag = "R2";

    function automatic logic signed [15:0] mac(input longint c0, input longint a,
                                               input longint c1, input longint b);
        longint s;
        s = ((c0 * a) >>> F) + ((c1 * b) >>> F);
        return 16'(s);
    endfunction

    task automatic build_exp(input int cols, input int rows);
        longint ca, cb, da, db;
        int m, sx, sy;
        ca = longint'(cfg_ca); cb = longint'(cfg_cb);
        da = longint'(cfg_da); db = longint'(cfg_db);
        m = int'(cfg_margin); sx = int'(cfg_src_x); sy = int'(cfg_src_y);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                longint hw, hn;
                bit bnd;
                bnd = (c < m) || (c >= cols - m) || (r < m) || (r >= rows - m);
                hw = (c > 0) ? longint'(ghz[r][c-1]) : 0;
                hn = (r > 0) ? longint'(ghz[r-1][c]) : 0;
                eex[r][c] = bnd ? 16'sd0 : mac(ca, gex[r][c], cb, longint'(ghz[r][c]) - hw);
                eey[r][c] = bnd ? 16'sd0 : mac(ca, gey[r][c], cb, hn - longint'(ghz[r][c]));
                ecls[r][c] = (c == sx && r == sy) ? 2 : (bnd ? 1 : 0);
            end
        end
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                longint xe, ys, d;
                xe = (c < cols - 1) ? longint'(gex[r][c+1]) : 0;
                ys = (r < rows - 1) ? longint'(eey[r+1][c]) : 0;
                d  = xe - longint'(gex[r][c]) + longint'(eey[r][c]) - ys;
                if (ecls[r][c] == 2)      ehz[r][c] = src_value;
                else if (ecls[r][c] == 1) ehz[r][c] = 16'sd0;
                else                      ehz[r][c] = mac(da, ghz[r][c], db, d);
            end
        end
    endtask

    // ---------------- cycle model and comparison ----------------
    int  b_st = 0;      // 0 idle, 1 taking input, 2 draining
    int  b_cnt = 0, b_oc = 0, b_total = 0, b_cols = 2, b_rows = 1;
    bit  exp_v = 0, exp_done = 0;
    int  exp_idx = 0;
    int  n_out = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(out_valid == exp_v, "R7", out_valid, exp_v);
            chk(done == exp_done, "R9", done, exp_done);
            if (exp_v && out_valid) begin
                int r, c;
                r = exp_idx / b_cols;
                c = exp_idx % b_cols;
                n_out++;
                chk(out_ex == eex[r][c], (ecls[r][c] == 1) ? "R5" : ex_tag, out_ex, eex[r][c]);
                chk(out_ey == eey[r][c], (ecls[r][c] == 1) ? "R5" : "R3", out_ey, eey[r][c]);
                chk(out_hz == ehz[r][c], (ecls[r][c] == 2) ? "R6" :
                                         ((ecls[r][c] == 1) ? "R5" : "R4"), out_hz, ehz[r][c]);
            end
            // predict the effect of the coming edge
            exp_v = 0;
            if (b_st == 0 && start) begin
                b_cols = int'(cfg_cols); b_rows = int'(cfg_rows);
                b_total = b_cols * b_rows;
                build_exp(b_cols, b_rows);   // R11: values captured at start
                b_st = 1; b_cnt = 0; b_oc = 0; exp_done = 0; n_out = 0;
            end else if ((b_st == 1 && in_valid) || b_st == 2) begin
                if (b_cnt >= b_cols + 1) begin
                    exp_v = 1;
                    exp_idx = b_oc;
                    b_oc++;
                    if (b_oc == b_total) begin
                        b_st = 0;
                        exp_done = 1;
                    end
                end
                b_cnt++;
                if (b_st == 1 && b_cnt == b_total) b_st = 2;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic feed(input int cols, input int rows, input bit gaps, input int chg_at);
        for (int i = 0; i < cols * rows; i++) begin
            in_valid = 1'b1;
            in_ex = gex[i / cols][i % cols];
            in_ey = gey[i / cols][i % cols];
            in_hz = ghz[i / cols][i % cols];
            if (i == chg_at) begin   // R11: mid-run configuration change
                cfg_ca = 16'sd100; cfg_cols = 5'd3; cfg_margin = 5'd0;
            end
            tick();
            in_valid = 1'b0;
            if (gaps && (i % 3 == 2)) tick();
        end
        // R8: surplus points after the grid is complete
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1; in_ex = 16'sd777; in_ey = -16'sd777; in_hz = 16'sd555;
            tick();
        end
        in_valid = 1'b0;
    endtask

    task automatic finish_run(input int total);
        for (int k = 0; k < 200 && !done; k++) tick();
        repeat (4) tick();
        chk(done == 1'b1, "R9", done, 1);
        chk(n_out == total, "R8", n_out, total);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(done == 1'b0, "R1", done, 0);
        tick();

        // Run 1: 5x6 grid, margin 1, source inside, continuous, config change mid-run
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++) begin
                gex[r][c] = 16'(((r * 37 + c * 101) % 401) - 200);
                gey[r][c] = 16'(((r * 53 + c * 29 + 7) % 333) - 160);
                ghz[r][c] = 16'(((r * 71 + c * 13 + 3) % 517) - 250);
            end
        cfg_ca = 16'sd3686; cfg_cb = 16'sd2048; cfg_da = 16'sd3277; cfg_db = 16'sd1024;
        cfg_cols = 5'd5; cfg_rows = 5'd6; cfg_margin = 5'd1;
        cfg_src_x = 5'd2; cfg_src_y = 5'd3; src_value = 16'sd1234;
        ex_tag = "R11";
        in_valid = 1'b1; in_ex = 16'sd99; tick(); tick();   // R8: ignored while idle
        in_valid = 1'b0;
        pulse_start();
        feed(5, 6, 1'b0, 10);
        finish_run(30);

        // Run 2: 8x3 grid, no margin, source outside grid, gapped input
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 8; c++) begin
                gex[r][c] = 16'(((r * 211 + c * 97 + 5) % 1201) - 600);
                gey[r][c] = 16'(((r * 19 + c * 173 + 1) % 999) - 500);
                ghz[r][c] = 16'(((r * 131 + c * 61 + 9) % 1501) - 750);
            end
        cfg_ca = 16'sd4096; cfg_cb = -16'sd1536; cfg_da = 16'sd2048; cfg_db = 16'sd3000;
        cfg_cols = 5'd8; cfg_rows = 5'd3; cfg_margin = 5'd0;
        cfg_src_x = 5'd15; cfg_src_y = 5'd15; src_value = -16'sd42;
        ex_tag = "R2";
        pulse_start();
        feed(8, 3, 1'b1, -1);
        finish_run(24);

        // Run 3: 6x4 grid, extreme values and large coefficients to force wrap, source at corner
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 6; c++) begin
                gex[r][c] = ((r + c) % 2 == 0) ? 16'sd32767 : -16'sd32768;
                gey[r][c] = ((r * 3 + c) % 3 == 0) ? -16'sd32768 : 16'sd32000;
                ghz[r][c] = (c % 2 == 0) ? -16'sd31000 : 16'sd32767;
            end
        cfg_ca = 16'sd32767; cfg_cb = 16'sd32767; cfg_da = -16'sd32768; cfg_db = 16'sd32767;
        cfg_cols = 5'd6; cfg_rows = 5'd4; cfg_margin = 5'd0;
        cfg_src_x = 5'd0; cfg_src_y = 5'd0; src_value = 16'sd7;
        ex_tag = "R10";
        pulse_start();
        feed(6, 4, 1'b0, -1);
        finish_run(24);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule